// File: doc/BRIEF.md
# Per-Port Back-Pressure Command Generator

This block sits next to a shared cell buffer at the receiving end of a link. It watches how full each of 31 port queues is, and how full the shared buffer is overall. From that it builds a 32-bit flow-control command for the far end. Each port has its own threshold register, and so does the buffer total. A port whose queue has reached its threshold is told to halt. If the total occupancy reaches the global threshold, every port is told to halt.

The command word holds one bit per port, where 1 means halt and 0 means send. The word is split into four bytes, with the highest bit reserved. A snapshot is taken at each flow-control opportunity, marked by a one-cycle `fc_tick`. The snapshot leaves the block on a valid/ready stream.

Back-pressure rules for the output stream:
- A word is handed over on a cycle where `cmd_valid` and `cmd_ready` are both high.
- While `cmd_valid` is high and `cmd_ready` is low, the word is held unchanged, and any `fc_tick` in that time is dropped.
- A tick on a handshake cycle loads the next snapshot at once, so back-to-back words need no idle cycle.

Top module: `fc_cmd_gen`

## Requirements
- R1: Port p's command bit is 1 (halt) when its fill level, zero-extended, is greater than or equal to its threshold. Otherwise the bit is 0 (send). Each port is independent of the others.
- R2: Bit p of `cmd_data` carries port p. Byte 0 (bits 7:0) holds ports 7..0, byte 1 (bits 15:8) holds ports 15..8, byte 2 (bits 23:16) holds ports 23..16, and byte 3 (bits 30:24) holds ports 30..24.
- R3: Bit 31 of `cmd_data` is reserved and always 0.
- R4: When `total_fill` is greater than or equal to the global threshold, bits 30:0 are all 1, whatever the per-port results are.
- R5: After reset every threshold is all ones at TOT_W bits wide. As a result no port halts from its own threshold after reset, whatever its fill level.
- R6: A cycle with `cfg_we` high writes `cfg_wdata` into one threshold:
  - `cfg_sel` 0..30 selects the threshold of that port.
  - `cfg_sel` 31 selects the global threshold.
  - The new value applies to ticks on later cycles.
- R7: A `fc_tick` while the output is free (`cmd_valid` low, or `cmd_ready` high) captures a snapshot of the current inputs. `cmd_valid` is high with that word in the next cycle.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high, `cmd_data` stays stable, and ticks are ignored.
- R9: After a handshake with no tick in the same cycle, `cmd_valid` is low in the next cycle.
- R10: Out of reset, `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Threshold write enable |
| cfg_sel | input | 5 | Threshold select: 0..30 for a port, 31 for global |
| cfg_wdata | input | TOT_W | Threshold value to write |
| port_fill | input | 31*FILL_W | Per-port fill levels; port p is at bits [p*FILL_W +: FILL_W] |
| total_fill | input | TOT_W | Occupancy of the whole shared buffer |
| fc_tick | input | 1 | Flow-control opportunity strobe |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Consumer accepts the command word |
| cmd_data | output | 32 | Packed halt/send bits, with bit 31 reserved |

## Verification
A corrupted threshold register does not show up until the next tick. After that tick, the word shows a halt bit flipped at one port position, one cycle later. A fault in the output register shows up while the consumer stalls: either the word changes before the handshake completes, or a dropped tick leaves an extra word behind. The scoreboard catches the extra word as an unexpected entry. A packing error moves a bit into a neighbouring byte, and the first snapshot with a single port halted exposes it.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int FC_PORTS      = 31;
  localparam int FC_BYTES      = 4;
  localparam int FC_WORD_W     = 8 * FC_BYTES;
  localparam int FC_SEL_W      = 5;
  localparam int FC_GLOBAL_SEL = 31;

  typedef logic [FC_PORTS-1:0]  fc_halt_t;
  typedef logic [FC_WORD_W-1:0] fc_word_t;
endpackage

// File: rtl/fc_thr_regs.sv
module fc_thr_regs import fc_pkg::*; #(
  parameter int TOT_W = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [FC_SEL_W-1:0]         cfg_sel,
  input  logic [TOT_W-1:0]            cfg_wdata,
  output logic [FC_PORTS*TOT_W-1:0]   port_thr,
  output logic [TOT_W-1:0]            glob_thr
);
  localparam logic [TOT_W-1:0] THR_RST = '1;

  for (genvar p = 0; p < FC_PORTS; p++) begin : g_port_thr
    logic [TOT_W-1:0] thr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        thr_q <= THR_RST;
      else if (cfg_we && (cfg_sel == FC_SEL_W'(p)))
        thr_q <= cfg_wdata;
    end
    assign port_thr[p*TOT_W +: TOT_W] = thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      glob_thr <= THR_RST;
    else if (cfg_we && (cfg_sel == FC_SEL_W'(FC_GLOBAL_SEL)))
      glob_thr <= cfg_wdata;
  end
endmodule

// File: rtl/fc_port_cmp.sv
module fc_port_cmp import fc_pkg::*; #(
  parameter int FILL_W = 10,
  parameter int TOT_W  = 14
) (
  input  logic [FC_PORTS*FILL_W-1:0] port_fill,
  input  logic [FC_PORTS*TOT_W-1:0]  port_thr,
  input  logic [TOT_W-1:0]           total_fill,
  input  logic [TOT_W-1:0]           glob_thr,
  output fc_halt_t                   halt
);
  logic glob_hit;
  assign glob_hit = (total_fill >= glob_thr);

  for (genvar p = 0; p < FC_PORTS; p++) begin : g_cmp
    logic [TOT_W-1:0] fill_ext;
    logic             own_hit;
    assign fill_ext = TOT_W'(port_fill[p*FILL_W +: FILL_W]);
    assign own_hit  = (fill_ext >= port_thr[p*TOT_W +: TOT_W]);
    assign halt[p]  = own_hit | glob_hit;
  end
endmodule

// File: rtl/fc_pack.sv
module fc_pack import fc_pkg::*; (
  input  fc_halt_t halt,
  output fc_word_t word
);
  for (genvar b = 0; b < FC_BYTES; b++) begin : g_byte
    for (genvar j = 0; j < 8; j++) begin : g_bit
      localparam int IDX = 8 * b + j;
      if (IDX < FC_PORTS) begin : g_port
        assign word[IDX] = halt[IDX];
      end else begin : g_rsvd
        assign word[IDX] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/fc_cmd_out.sv
module fc_cmd_out import fc_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     fc_tick,
  input  fc_word_t snap,
  output logic     cmd_valid,
  input  logic     cmd_ready,
  output fc_word_t cmd_data
);
  logic slot_free;
  logic load;
  assign slot_free = !cmd_valid || cmd_ready;
  assign load      = fc_tick && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else if (load) begin
      cmd_valid <= 1'b1;
      cmd_data  <= snap;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fc_cmd_gen.sv
module fc_cmd_gen import fc_pkg::*; #(
  parameter int FILL_W = 10,
  parameter int TOT_W  = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [FC_SEL_W-1:0]         cfg_sel,
  input  logic [TOT_W-1:0]            cfg_wdata,
  input  logic [FC_PORTS*FILL_W-1:0]  port_fill,
  input  logic [TOT_W-1:0]            total_fill,
  input  logic                        fc_tick,
  output logic                        cmd_valid,
  input  logic                        cmd_ready,
  output logic [FC_WORD_W-1:0]        cmd_data
);
  logic [FC_PORTS*TOT_W-1:0] port_thr;
  logic [TOT_W-1:0]          glob_thr;
  fc_halt_t                  halt;
  fc_word_t                  snap;

  fc_thr_regs #(.TOT_W(TOT_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .port_thr(port_thr), .glob_thr(glob_thr)
  );

  fc_port_cmp #(.FILL_W(FILL_W), .TOT_W(TOT_W)) u_cmp (
    .port_fill(port_fill), .port_thr(port_thr), .total_fill(total_fill),
    .glob_thr(glob_thr), .halt(halt)
  );

  fc_pack u_pack (.halt(halt), .word(snap));

  fc_cmd_out u_out (
    .clk(clk), .rst_n(rst_n), .fc_tick(fc_tick), .snap(snap),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data)
  );
endmodule

// File: rtl/fc_cmd_gen_chk.sv
module fc_cmd_gen_chk import fc_pkg::*; #(
  parameter int TOT_W = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fc_tick,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [FC_WORD_W-1:0] cmd_data,
  input logic [TOT_W-1:0]     total_fill,
  input logic [TOT_W-1:0]     glob_thr
);
  // R3
  rsvd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !cmd_data[FC_WORD_W-1]);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_tick && (!cmd_valid || cmd_ready)) |=> cmd_valid);

  // R9
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !fc_tick) |=> !cmd_valid);

  // R4
  glob_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_tick && (!cmd_valid || cmd_ready) && (total_fill >= glob_thr))
    |=> (cmd_data[FC_PORTS-1:0] == {FC_PORTS{1'b1}}));
endmodule

bind fc_cmd_gen fc_cmd_gen_chk #(.TOT_W(TOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fc_tick(fc_tick), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_data(cmd_data), .total_fill(total_fill),
  .glob_thr(glob_thr)
);

// File: tb/fc_cmd_gen_tb.sv
module fc_cmd_gen_tb;
  import fc_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int FILL_W = 10;
  localparam int TOT_W  = 14;

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic                       cfg_we = 1'b0;
  logic [FC_SEL_W-1:0]        cfg_sel = '0;
  logic [TOT_W-1:0]           cfg_wdata = '0;
  logic [FC_PORTS*FILL_W-1:0] port_fill = '0;
  logic [TOT_W-1:0]           total_fill = '0;
  logic                       fc_tick = 1'b0;
  logic                       cmd_valid;
  logic                       cmd_ready = 1'b1;
  logic [FC_WORD_W-1:0]       cmd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_cmd_gen #(.FILL_W(FILL_W), .TOT_W(TOT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .port_fill(port_fill), .total_fill(total_fill),
    .fc_tick(fc_tick), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [TOT_W-1:0]  thr_m [FC_PORTS];
  logic [TOT_W-1:0]  gthr_m;
  logic [FILL_W-1:0] fills [FC_PORTS];
  logic [FC_WORD_W-1:0] exp_q [$];
  string                tag_q [$];

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [FC_WORD_W-1:0] model_word();
    logic [FC_WORD_W-1:0] w = '0;
    for (int p = 0; p < FC_PORTS; p++)
      w[p] = (TOT_W'(fills[p]) >= thr_m[p]) || (total_fill >= gthr_m);
    return w;
  endfunction

  task automatic apply_fills();
    for (int p = 0; p < FC_PORTS; p++)
      port_fill[p*FILL_W +: FILL_W] = fills[p];
  endtask

  task automatic write_thr(input int sel, input logic [TOT_W-1:0] v);
    @(posedge clk); #2;
    cfg_we = 1'b1; cfg_sel = FC_SEL_W'(sel); cfg_wdata = v;
    @(posedge clk); #2;
    cfg_we = 1'b0;
    if (sel == FC_GLOBAL_SEL) gthr_m = v; else thr_m[sel] = v;
  endtask

  // Driver: drives one tick and pushes the expected word if it is accepted.
  task automatic tick(input string tag);
    @(posedge clk); #2;
    apply_fills();
    fc_tick = 1'b1;
    if (!cmd_valid || cmd_ready) begin
      exp_q.push_back(model_word());
      tag_q.push_back(tag);
    end
    @(posedge clk); #2;
    fc_tick = 1'b0;
  endtask

  // Monitor: a handshake seen mid-cycle completes at the next rising edge.
  always @(negedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected word", cmd_data, '0);
      end else begin
        logic [FC_WORD_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cmd_data == e, t, cmd_data, e);
        chk(cmd_data[31] == 1'b0, "R3 reserved bit", {31'b0, cmd_data[31]}, 32'h0);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int p = 0; p < FC_PORTS; p++) begin
      thr_m[p] = '1;
      fills[p] = FILL_W'(p * 7);
    end
    gthr_m = '1;
    total_fill = 14'd2000;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R10: no word after reset
    chk(cmd_valid == 1'b0, "R10 valid after reset", {31'b0, cmd_valid}, 32'h0);

    // R5: default thresholds, even full queues do not halt
    tick("R5 defaults send");
    fills[0] = '1;
    tick("R5 full queue under default threshold");
    drain();

    // R1 and R6: own threshold boundary on port 3
    write_thr(3, 14'd100);
    fills[3] = 10'd99;  tick("R1 below threshold");
    fills[3] = 10'd100; tick("R1 at threshold");
    fills[3] = 10'd400; tick("R1 above threshold");
    drain();

    // R2: one port in each byte
    write_thr(8, 14'd5);  write_thr(16, 14'd5); write_thr(30, 14'd5);
    fills[3] = 10'd0;
    fills[8] = 10'd5; tick("R2 port 8 in byte 1");
    fills[8] = 10'd0; fills[16] = 10'd5; tick("R2 port 16 in byte 2");
    fills[16] = 10'd0; fills[30] = 10'd5; tick("R2 port 30 in byte 3");
    drain();
    chk(cmd_valid == 1'b0, "R9 idle after drain", {31'b0, cmd_valid}, 32'h0);

    // R2: alternating pattern over all ports
    for (int p = 0; p < FC_PORTS; p++) begin
      thr_m[p] = thr_m[p];
      write_thr(p, 14'd50);
      fills[p] = (p % 2 == 1) ? 10'd50 : 10'd49;
    end
    tick("R2 alternating pattern");
    drain();

    // R4: global threshold
    write_thr(FC_GLOBAL_SEL, 14'd1000);
    total_fill = 14'd999;  tick("R4 total below global");
    total_fill = 14'd1000; tick("R4 total at global");
    total_fill = 14'd3;    tick("R4 released");
    drain();

    // R8: stall holds the word and drops ticks
    cmd_ready = 1'b0;
    fills[0] = 10'd60;
    tick("R8 word held across stall");
    fills[0] = 10'd0;
    tick("R8 ignored tick");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cmd_valid == 1'b1, "R8 valid held", {31'b0, cmd_valid}, 32'h1);
      chk(cmd_data == exp_q[0], "R8 data stable", cmd_data, exp_q[0]);
    end
    @(posedge clk); #2 cmd_ready = 1'b1;
    drain();

    // R7 and R9: back-to-back ticks, then idle
    fills[1] = 10'd0; fills[2] = 10'd50;
    @(posedge clk); #2;
    apply_fills();
    fc_tick = 1'b1;
    exp_q.push_back(model_word()); tag_q.push_back("R7 first back-to-back");
    @(posedge clk); #2;
    fills[2] = 10'd0;
    apply_fills();
    exp_q.push_back(model_word()); tag_q.push_back("R7 second back-to-back");
    @(posedge clk); #2;
    fc_tick = 1'b0;
    drain();
    chk(cmd_valid == 1'b0, "R9 valid drops after handshake", {31'b0, cmd_valid}, 32'h0);

    finish_run();
  end
endmodule